// File: doc/BRIEF.md
# Packet Page Allocator with Command Decoder

This block owns a small pool of fixed-size packet buffer pages inside a network controller. It tracks which pages are taken in a bit vector and keeps three page-number queues: pages that hold received frames waiting for the host, pages the host has handed over for sending, and sent pages waiting for the host to collect them. Page storage, the frame data path and bus decoding sit outside. The block only hands out page numbers, moves them between queues and raises interrupt status.

The host drives a byte-wide command strobe. Bits 7:5 of the byte select one of eight operations: allocate, free, queue moves, and two kinds of reset. A transmit allocation that finds the pool full stays pending. It is retried on every cycle until a page becomes free. The receive path asks for a page on its own request pin and gets the answer in the same cycle. The transmit path receives one start pulse per queued page and reports the end of each frame on a completion pin.

Top module: `pkt_page_alloc`

## Requirements
- R1: The pool holds NUM_PAGES pages (default 4). Every allocation takes the lowest-numbered free page. `pages_used` reports the number of taken pages and `pool_size` reports NUM_PAGES.
- R2: A command with code 1 (allocate for transmit) takes effect in the same cycle. If a page is free and no receive request wins it, `alloc_result` becomes the page number and status bit 3 (allocation done) is set. Otherwise `alloc_result` becomes 0x80, bit 3 is cleared and the request stays pending.
- R3: A pending transmit allocation is granted in the first cycle that has a free page and no receive request. A receive request always wins the page over a transmit allocation in the same cycle.
- R4: When `rx_alloc_req` is high, no code 2 command is present and a page is free, `rx_alloc_ok` and `rx_alloc_page` respond combinationally. The page is then appended to the receive queue and status bit 0 (receive) is set.
- R5: `rxq_head` and `doneq_head` read 0x80 when their queue is empty. Otherwise they show the page number at the head of the queue.
- R6: Code 3 removes the receive queue head. Code 4 removes the head and also frees that page. After such a removal, bit 0 stays set if entries remain and is cleared if the queue is now empty.
- R7: Code 5 frees the page held in the packet-number register (loaded through `pnum_we`).
- R8: Code 6 appends the packet-number page to the transmit queue. While no frame is in flight, the block takes the head and pulses `tx_start` for one cycle with `tx_page`, one cycle after the dequeue. It then waits for `tx_done` before starting the next frame.
- R9: On `tx_done` the in-flight page is freed if `auto_release` is high. Otherwise it is appended to the completion queue. An acknowledge with bit 1 set removes the completion queue head.
- R10: Status bit 2 is set in any cycle the transmit queue is empty. Bit 1 is set while the completion queue holds entries. `irq` is high when `int_status & int_mask` is nonzero.
- R11: An acknowledge write clears only the status bits in `ack_byte & 0xD6`, so bits 0 and 3 survive it.
- R12: Code 2 empties the pool and all queues, drops the pending allocation and any frame in flight, sets `alloc_result` to 0, and refuses a receive request in the same cycle. Code 7 empties the transmit and completion queues only.
- R13: A push into a full queue (depth QDEPTH) is ignored, and so is a removal from an empty queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command strobe |
| cmd_byte | input | 8 | Command byte; bits 7:5 hold the code |
| pnum_we | input | 1 | Load the packet-number register |
| pnum_page | input | PW | New packet-number value |
| auto_release | input | 1 | Free sent pages instead of queueing them |
| rx_alloc_req | input | 1 | Receive path asks for a page |
| rx_alloc_ok | output | 1 | Receive page granted this cycle |
| rx_alloc_page | output | PW | Granted receive page |
| tx_start | output | 1 | One-cycle frame start pulse |
| tx_page | output | PW | Page of the frame being started |
| tx_done | input | 1 | In-flight frame finished |
| ack_we | input | 1 | Interrupt acknowledge strobe |
| ack_byte | input | 8 | Bits to acknowledge |
| mask_we | input | 1 | Interrupt mask write strobe |
| mask_byte | input | 8 | New interrupt mask |
| alloc_result | output | 8 | Transmit allocation result, 0x80 when failed or pending |
| rxq_head | output | 8 | Receive queue head or 0x80 |
| doneq_head | output | 8 | Completion queue head or 0x80 |
| pages_used | output | 8 | Count of taken pages |
| pool_size | output | 8 | Number of pages in the pool |
| int_status | output | 8 | Interrupt status bits |
| int_mask | output | 8 | Interrupt mask |
| irq | output | 1 | Interrupt line |

## Verification
Two pairs of functions can meet in one cycle. A receive page request can arrive while a transmit allocation is issued or pending. A frame completion can push onto the completion queue while an acknowledge pops it. The bench sets up both on purpose: it raises the receive request together with an allocate command, and it raises `tx_done` together with an acknowledge of bit 1. A random phase then overlaps all inputs freely. A behavioural model built on integer queues applies the stated precedence in every cycle: receive before transmit, frees visible from the next cycle, and clears before pushes. It is compared against every output after each edge.

// File: rtl/pkt_alloc_pkg.sv
`timescale 1ns/1ps
package pkt_alloc_pkg;

  typedef enum logic [2:0] {
    CMD_NOP         = 3'd0,
    CMD_TX_ALLOC    = 3'd1,
    CMD_MGR_RESET   = 3'd2,
    CMD_RX_POP      = 3'd3,
    CMD_RX_POP_FREE = 3'd4,
    CMD_FREE        = 3'd5,
    CMD_TX_ENQ      = 3'd6,
    CMD_TX_CLR      = 3'd7
  } mgr_cmd_e;

  localparam int ST_RCV     = 0;
  localparam int ST_TXDONE  = 1;
  localparam int ST_TXEMPTY = 2;
  localparam int ST_ALLOC   = 3;

  localparam logic [7:0] ACK_CLEARABLE = 8'hD6;
  localparam logic [7:0] NO_PAGE       = 8'h80;
  localparam logic [7:0] STATUS_RESET  = 8'h04;

  // index of the lowest clear bit among the low n bits, -1 when none
  function automatic int first_zero(input logic [31:0] v, input int n);
    int r;
    r = -1;
    for (int i = 31; i >= 0; i--) begin
      if (i < n && !v[i]) r = i;
    end
    return r;
  endfunction

  // number of set bits among the low n bits
  function automatic int ones(input logic [31:0] v, input int n);
    int c;
    c = 0;
    for (int i = 0; i < 32; i++) begin
      if (i < n && v[i]) c++;
    end
    return c;
  endfunction

  // ring pointer advance
  function automatic int ring_next(input int p, input int depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/page_fifo.sv
`timescale 1ns/1ps
module page_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 2,
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  head,
  output logic [CW-1:0] count,
  output logic [CW-1:0] count_nxt
);
  import pkt_alloc_pkg::*;

  logic [W-1:0]    mem [DEPTH];
  logic [PTRW-1:0] rd_q, wr_q;
  logic            push_ok, pop_ok;

  assign pop_ok  = pop  && (count != '0) && !clr;
  assign push_ok = push && (count != CW'(DEPTH)) && !clr;

  always_comb begin
    if (clr) count_nxt = '0;
    else     count_nxt = count + CW'(push_ok) - CW'(pop_ok);
  end

  assign head = mem[rd_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      count <= '0;
    end else begin
      count <= count_nxt;
      if (clr) begin
        rd_q <= '0;
        wr_q <= '0;
      end else begin
        if (pop_ok)  rd_q <= PTRW'(ring_next(int'(rd_q), DEPTH));
        if (push_ok) wr_q <= PTRW'(ring_next(int'(wr_q), DEPTH));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_q] <= push_data;
  end

endmodule

// File: rtl/page_pool.sv
`timescale 1ns/1ps
module page_pool #(
  parameter int NUM_PAGES = 4,
  localparam int PW  = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
  localparam int UCW = $clog2(NUM_PAGES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic [NUM_PAGES-1:0] free_vec,
  input  logic                 rx_req,
  input  logic                 tx_req,
  output logic                 any_free,
  output logic [PW-1:0]        grant_page,
  output logic                 rx_grant,
  output logic                 tx_grant,
  output logic [UCW-1:0]       used_cnt
);
  import pkt_alloc_pkg::*;

  logic [NUM_PAGES-1:0] used_q, used_nxt, take_vec;
  int                   low;

  always_comb begin
    low        = first_zero(32'(used_q), NUM_PAGES);
    any_free   = (low >= 0);
    grant_page = any_free ? PW'(low) : '0;
  end

  // receive wins the page; transmit only takes it when receive is idle
  assign rx_grant = rx_req && any_free;
  assign tx_grant = tx_req && any_free && !rx_req;
  assign take_vec = (rx_grant || tx_grant) ? (NUM_PAGES'(1) << grant_page) : '0;
  assign used_nxt = clr ? '0 : ((used_q & ~free_vec) | take_vec);
  assign used_cnt = UCW'(ones(32'(used_q), NUM_PAGES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) used_q <= '0;
    else        used_q <= used_nxt;
  end

endmodule

// File: rtl/irq_ctrl.sv
`timescale 1ns/1ps
module irq_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ack_we,
  input  logic [7:0] ack_val,
  input  logic       mask_we,
  input  logic [7:0] mask_val,
  input  logic       alloc_clr,
  input  logic       alloc_set,
  input  logic       rcv_set,
  input  logic       rcv_pop,
  input  logic       rcv_left,
  input  logic       txq_empty_nxt,
  input  logic       done_busy_nxt,
  output logic [7:0] status,
  output logic [7:0] mask,
  output logic       irq
);
  import pkt_alloc_pkg::*;

  logic [7:0] st_nxt;

  always_comb begin
    st_nxt = status;
    if (alloc_clr) st_nxt[ST_ALLOC] = 1'b0;
    if (ack_we)    st_nxt = st_nxt & ~(ack_val & ACK_CLEARABLE);
    if (alloc_set) st_nxt[ST_ALLOC] = 1'b1;
    if (rcv_set)      st_nxt[ST_RCV] = 1'b1;
    else if (rcv_pop) st_nxt[ST_RCV] = rcv_left;
    if (txq_empty_nxt) st_nxt[ST_TXEMPTY] = 1'b1;
    if (done_busy_nxt) st_nxt[ST_TXDONE]  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= STATUS_RESET;
      mask   <= '0;
    end else begin
      status <= st_nxt;
      if (mask_we) mask <= mask_val;
    end
  end

  assign irq = |(status & mask);

endmodule

// File: rtl/pkt_page_alloc.sv
`timescale 1ns/1ps
module pkt_page_alloc #(
  parameter int NUM_PAGES = 4,
  parameter int QDEPTH    = 4,
  localparam int PW  = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
  localparam int QCW = $clog2(QDEPTH + 1),
  localparam int UCW = $clog2(NUM_PAGES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_we,
  input  logic [7:0]    cmd_byte,
  input  logic          pnum_we,
  input  logic [PW-1:0] pnum_page,
  input  logic          auto_release,
  input  logic          rx_alloc_req,
  output logic          rx_alloc_ok,
  output logic [PW-1:0] rx_alloc_page,
  output logic          tx_start,
  output logic [PW-1:0] tx_page,
  input  logic          tx_done,
  input  logic          ack_we,
  input  logic [7:0]    ack_byte,
  input  logic          mask_we,
  input  logic [7:0]    mask_byte,
  output logic [7:0]    alloc_result,
  output logic [7:0]    rxq_head,
  output logic [7:0]    doneq_head,
  output logic [7:0]    pages_used,
  output logic [7:0]    pool_size,
  output logic [7:0]    int_status,
  output logic [7:0]    int_mask,
  output logic          irq
);
  import pkt_alloc_pkg::*;

  // ---------------- command decode ----------------
  mgr_cmd_e cmd;
  logic     cmd_alloc, cmd_reset, cmd_rx_pop, cmd_rx_free, cmd_free, cmd_enq, cmd_txclr;
  logic     unused_cmd_bits;

  assign cmd         = cmd_we ? mgr_cmd_e'(cmd_byte[7:5]) : CMD_NOP;
  assign cmd_alloc   = (cmd == CMD_TX_ALLOC);
  assign cmd_reset   = (cmd == CMD_MGR_RESET);
  assign cmd_rx_pop  = (cmd == CMD_RX_POP);
  assign cmd_rx_free = (cmd == CMD_RX_POP_FREE);
  assign cmd_free    = (cmd == CMD_FREE);
  assign cmd_enq     = (cmd == CMD_TX_ENQ);
  assign cmd_txclr   = (cmd == CMD_TX_CLR);
  assign unused_cmd_bits = ^cmd_byte[4:0];

  // ---------------- state registers ----------------
  logic [PW-1:0] pnum_q;
  logic          pend_q;
  logic [7:0]    res_q;
  logic          busy_q;
  logic          start_q;
  logic [PW-1:0] inflight_q;

  // ---------------- queues ----------------
  logic [PW-1:0]  rxq_raw, txq_raw, doneq_raw;
  logic [QCW-1:0] rxq_cnt, rxq_cnt_nxt, txq_cnt, txq_cnt_nxt, doneq_cnt, doneq_cnt_nxt;

  // ---------------- pool signals ----------------
  logic                 any_free, rx_grant, tx_grant;
  logic [PW-1:0]        grant_page;
  logic [UCW-1:0]       used_cnt;
  logic [NUM_PAGES-1:0] free_vec;
  logic                 free_any;
  logic                 rx_req_eff, tx_req;

  // ---------------- named internal events ----------------
  logic issue, done_evt, done_push, done_pop, rx_pop_any, rx_popped;

  assign issue      = !busy_q && (txq_cnt != '0) && !cmd_reset && !cmd_txclr;
  assign done_evt   = busy_q && tx_done && !cmd_reset;
  assign done_push  = done_evt && !auto_release;
  assign done_pop   = ack_we && ack_byte[ST_TXDONE];
  assign rx_pop_any = cmd_rx_pop || cmd_rx_free;
  assign rx_popped  = rx_pop_any && (rxq_cnt != '0);

  assign rx_req_eff = rx_alloc_req && !cmd_reset;
  assign tx_req     = (cmd_alloc || pend_q) && !cmd_reset;

  always_comb begin
    free_vec = '0;
    if (cmd_rx_free && rxq_cnt != '0) free_vec = free_vec | (NUM_PAGES'(1) << rxq_raw);
    if (cmd_free)                     free_vec = free_vec | (NUM_PAGES'(1) << pnum_q);
    if (done_evt && auto_release)     free_vec = free_vec | (NUM_PAGES'(1) << inflight_q);
  end
  assign free_any = |free_vec;

  page_pool #(.NUM_PAGES(NUM_PAGES)) u_pool (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (cmd_reset),
    .free_vec   (free_vec),
    .rx_req     (rx_req_eff),
    .tx_req     (tx_req),
    .any_free   (any_free),
    .grant_page (grant_page),
    .rx_grant   (rx_grant),
    .tx_grant   (tx_grant),
    .used_cnt   (used_cnt)
  );

  page_fifo #(.DEPTH(QDEPTH), .W(PW)) u_rxq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (cmd_reset),
    .push      (rx_grant),
    .push_data (grant_page),
    .pop       (rx_pop_any),
    .head      (rxq_raw),
    .count     (rxq_cnt),
    .count_nxt (rxq_cnt_nxt)
  );

  page_fifo #(.DEPTH(QDEPTH), .W(PW)) u_txq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (cmd_reset || cmd_txclr),
    .push      (cmd_enq),
    .push_data (pnum_q),
    .pop       (issue),
    .head      (txq_raw),
    .count     (txq_cnt),
    .count_nxt (txq_cnt_nxt)
  );

  page_fifo #(.DEPTH(QDEPTH), .W(PW)) u_doneq (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (cmd_reset || cmd_txclr),
    .push      (done_push),
    .push_data (inflight_q),
    .pop       (done_pop),
    .head      (doneq_raw),
    .count     (doneq_cnt),
    .count_nxt (doneq_cnt_nxt)
  );

  irq_ctrl u_irq (
    .clk           (clk),
    .rst_n         (rst_n),
    .ack_we        (ack_we),
    .ack_val       (ack_byte),
    .mask_we       (mask_we),
    .mask_val      (mask_byte),
    .alloc_clr     (cmd_alloc),
    .alloc_set     (tx_grant),
    .rcv_set       (rx_grant),
    .rcv_pop       (rx_popped),
    .rcv_left      (rxq_cnt_nxt != '0),
    .txq_empty_nxt (txq_cnt_nxt == '0),
    .done_busy_nxt (doneq_cnt_nxt != '0),
    .status        (int_status),
    .mask          (int_mask),
    .irq           (irq)
  );

  // ---------------- sequential control ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pnum_q     <= '0;
      pend_q     <= 1'b0;
      res_q      <= '0;
      busy_q     <= 1'b0;
      start_q    <= 1'b0;
      inflight_q <= '0;
    end else begin
      if (pnum_we) pnum_q <= pnum_page;

      if (cmd_reset) begin
        pend_q <= 1'b0;
        res_q  <= '0;
      end else if (tx_grant) begin
        pend_q <= 1'b0;
        res_q  <= 8'(grant_page);
      end else if (cmd_alloc) begin
        pend_q <= 1'b1;
        res_q  <= NO_PAGE;
      end

      start_q <= issue;
      if (issue) inflight_q <= txq_raw;

      if (cmd_reset)     busy_q <= 1'b0;
      else if (issue)    busy_q <= 1'b1;
      else if (done_evt) busy_q <= 1'b0;
    end
  end

  // ---------------- outputs ----------------
  assign rx_alloc_ok   = rx_grant;
  assign rx_alloc_page = grant_page;
  assign tx_start      = start_q;
  assign tx_page       = inflight_q;
  assign alloc_result  = res_q;
  assign rxq_head      = (rxq_cnt   == '0) ? NO_PAGE : 8'(rxq_raw);
  assign doneq_head    = (doneq_cnt == '0) ? NO_PAGE : 8'(doneq_raw);
  assign pages_used    = 8'(used_cnt);
  assign pool_size     = 8'(NUM_PAGES);

endmodule

// File: rtl/pkt_page_alloc_chk.sv
`timescale 1ns/1ps
module pkt_page_alloc_chk #(
  parameter int NUM_PAGES = 4,
  parameter int QDEPTH    = 4,
  localparam int QCW = $clog2(QDEPTH + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           rx_alloc_ok,
  input logic           rx_alloc_req,
  input logic           free_any,
  input logic           any_free,
  input logic           cmd_alloc,
  input logic           cmd_reset,
  input logic           tx_grant,
  input logic           pend_q,
  input logic           tx_start,
  input logic [QCW-1:0] rxq_cnt,
  input logic [QCW-1:0] txq_cnt,
  input logic [7:0]     pages_used,
  input logic [7:0]     alloc_result,
  input logic [7:0]     rxq_head,
  input logic [7:0]     int_status
);

  assert_rx_alloc_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_alloc_ok && !free_any) |=> (pages_used == $past(pages_used) + 8'd1));

  assert_alloc_fail_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_alloc && !tx_grant) |=> (alloc_result == 8'h80));

  assert_retry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && any_free && !rx_alloc_req) |=> (alloc_result != 8'h80));

  assert_start_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> !tx_start);

  assert_txempty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (txq_cnt == '0) |-> int_status[2]);

  assert_mgr_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reset |=> (pages_used == 8'd0 && alloc_result == 8'd0 && rxq_head == 8'h80));

  assert_queue_bound_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rxq_cnt) <= QDEPTH) && (int'(txq_cnt) <= QDEPTH));

endmodule

bind pkt_page_alloc pkt_page_alloc_chk #(.NUM_PAGES(NUM_PAGES), .QDEPTH(QDEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rx_alloc_ok  (rx_alloc_ok),
  .rx_alloc_req (rx_alloc_req),
  .free_any     (free_any),
  .any_free     (any_free),
  .cmd_alloc    (cmd_alloc),
  .cmd_reset    (cmd_reset),
  .tx_grant     (tx_grant),
  .pend_q       (pend_q),
  .tx_start     (tx_start),
  .rxq_cnt      (rxq_cnt),
  .txq_cnt      (txq_cnt),
  .pages_used   (pages_used),
  .alloc_result (alloc_result),
  .rxq_head     (rxq_head),
  .int_status   (int_status)
);

// File: tb/pkt_page_alloc_tb.sv
`timescale 1ns/1ps
module pkt_page_alloc_tb;

  localparam int NP = 4;
  localparam int QD = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_we = 1'b0;
  logic [7:0] cmd_byte = '0;
  logic       pnum_we = 1'b0;
  logic [1:0] pnum_page = '0;
  logic       auto_release = 1'b0;
  logic       rx_alloc_req = 1'b0;
  logic       rx_alloc_ok;
  logic [1:0] rx_alloc_page;
  logic       tx_start;
  logic [1:0] tx_page;
  logic       tx_done = 1'b0;
  logic       ack_we = 1'b0;
  logic [7:0] ack_byte = '0;
  logic       mask_we = 1'b0;
  logic [7:0] mask_byte = '0;
  logic [7:0] alloc_result, rxq_head, doneq_head, pages_used, pool_size, int_status, int_mask;
  logic       irq;

  always #2 clk = ~clk;

  pkt_page_alloc #(.NUM_PAGES(NP), .QDEPTH(QD)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_byte(cmd_byte),
    .pnum_we(pnum_we), .pnum_page(pnum_page), .auto_release(auto_release),
    .rx_alloc_req(rx_alloc_req), .rx_alloc_ok(rx_alloc_ok), .rx_alloc_page(rx_alloc_page),
    .tx_start(tx_start), .tx_page(tx_page), .tx_done(tx_done),
    .ack_we(ack_we), .ack_byte(ack_byte), .mask_we(mask_we), .mask_byte(mask_byte),
    .alloc_result(alloc_result), .rxq_head(rxq_head), .doneq_head(doneq_head),
    .pages_used(pages_used), .pool_size(pool_size), .int_status(int_status),
    .int_mask(int_mask), .irq(irq)
  );

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  // ---------------- reference model state ----------------
  int m_used = 0;
  int rxq[$];
  int txq[$];
  int dq[$];
  bit m_pend = 0;
  int m_res = 0;
  bit m_busy = 0;
  bit m_start = 0;
  int m_infl = 0;
  int m_st = 'h04;
  int m_mask = 0;
  int m_pnum = 0;

  function automatic int lowest_free(input int u);
    for (int i = 0; i < NP; i++) if (((u >> i) & 1) == 0) return i;
    return -1;
  endfunction

  function automatic int popc(input int u);
    int c = 0;
    for (int i = 0; i < NP; i++) c += (u >> i) & 1;
    return c;
  endfunction

  function automatic int cur_cmd();
    return cmd_we ? int'(cmd_byte[7:5]) : 0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    int lf, c;
    bit ok;
    lf = lowest_free(m_used);
    c  = cur_cmd();
    ok = rx_alloc_req && (c != 2) && (lf >= 0);
    chk("R4 rx_alloc_ok", int'(rx_alloc_ok), int'(ok));
    if (ok) chk("R1 rx_alloc_page lowest free", int'(rx_alloc_page), lf);
    chk("R2 alloc_result", int'(alloc_result), m_res);
    chk("R5 rxq_head", int'(rxq_head), rxq.size() ? rxq[0] : 'h80);
    chk("R5 doneq_head", int'(doneq_head), dq.size() ? dq[0] : 'h80);
    chk("R1 pages_used", int'(pages_used), popc(m_used));
    chk("R1 pool_size", int'(pool_size), NP);
    chk("R10 int_status", int'(int_status), m_st);
    chk("R10 int_mask", int'(int_mask), m_mask);
    chk("R10 irq", int'(irq), int'((m_st & m_mask) != 0));
    chk("R8 tx_start", int'(tx_start), int'(m_start));
    if (m_start) chk("R8 tx_page", int'(tx_page), m_infl);
  endtask

  task automatic model_step();
    int c, fm, lf, nu, st, pre_full;
    bit rst_c, dn, rxg, txg, popped, issue;
    int old_infl;
    c = cur_cmd();
    rst_c = (c == 2);
    fm = 0;
    if (c == 4 && rxq.size() > 0) fm |= 1 << rxq[0];
    if (c == 5) fm |= 1 << m_pnum;
    dn = m_busy && tx_done && !rst_c;
    if (dn && auto_release) fm |= 1 << m_infl;
    lf  = lowest_free(m_used);
    rxg = rx_alloc_req && !rst_c && lf >= 0;
    txg = (c == 1 || m_pend) && !rst_c && lf >= 0 && !rx_alloc_req;
    nu  = rst_c ? 0 : ((m_used & ~fm) | ((rxg || txg) ? (1 << lf) : 0));

    st = m_st;
    if (c == 1) st &= ~'h08;
    if (ack_we) st &= ~(int'(ack_byte) & 'hD6);
    if (txg) st |= 'h08;

    // receive queue
    if (rst_c) rxq.delete();
    else begin
      pre_full = (rxq.size() >= QD);
      popped = 0;
      if ((c == 3 || c == 4) && rxq.size() > 0) begin void'(rxq.pop_front()); popped = 1; end
      if (rxg && !pre_full) rxq.push_back(lf);
      if (rxg) st |= 'h01;
      else if (popped) st = (rxq.size() > 0) ? (st | 'h01) : (st & ~'h01);
    end

    // transmit queue and sequencer
    old_infl = m_infl;
    issue = !m_busy && txq.size() > 0 && !rst_c && c != 7;
    m_start = issue;
    if (rst_c || c == 7) txq.delete();
    else begin
      pre_full = (txq.size() >= QD);
      if (issue) m_infl = txq.pop_front();
      if (c == 6 && !pre_full) txq.push_back(m_pnum);
    end
    if (rst_c) m_busy = 0;
    else if (issue) m_busy = 1;
    else if (dn) m_busy = 0;

    // completion queue
    if (rst_c || c == 7) dq.delete();
    else begin
      pre_full = (dq.size() >= QD);
      if (ack_we && ack_byte[1] && dq.size() > 0) void'(dq.pop_front());
      if (dn && !auto_release && !pre_full) dq.push_back(old_infl);
    end

    if (txq.size() == 0) st |= 'h04;
    if (dq.size() > 0) st |= 'h02;
    m_st = st;
    if (mask_we) m_mask = int'(mask_byte);

    if (rst_c) begin m_pend = 0; m_res = 0; end
    else if (txg) begin m_pend = 0; m_res = lf; end
    else if (c == 1) begin m_pend = 1; m_res = 'h80; end

    if (pnum_we) m_pnum = int'(pnum_page);
    m_used = nu;
  endtask

  // inputs are set at a falling edge before calling tick
  task automatic tick();
    #1 compare_all();
    @(posedge clk);
    model_step();
    @(negedge clk);
    cmd_we = 0; cmd_byte = '0; pnum_we = 0; rx_alloc_req = 0; tx_done = 0;
    ack_we = 0; ack_byte = '0; mask_we = 0; mask_byte = '0;
  endtask

  task automatic do_cmd(input int code);
    cmd_we = 1; cmd_byte = 8'(code << 5);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R8 watchdog actual=timeout expected=finish");
    summary();
  end

  logic [15:0] lfsr = 16'hACE1;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state (R1 R2 R5 R10)
    tick();
    chk("R10 status after reset", int'(int_status), 'h04);
    mask_we = 1; mask_byte = 8'hFF; tick();

    // receive allocations, receive beats a transmit allocate (R3 R4)
    rx_alloc_req = 1; tick();
    rx_alloc_req = 1; do_cmd(1); tick();
    chk("R3 rx wins, tx pending", int'(alloc_result), 'h80);
    tick();
    chk("R3 retry grants page 2", int'(alloc_result), 2);
    rx_alloc_req = 1; tick();
    rx_alloc_req = 1; tick();
    chk("R1 pool full", int'(pages_used), 4);

    // allocate with full pool, then free via pop-and-free (R2 R3 R6)
    do_cmd(1); tick();
    chk("R2 full pool result", int'(alloc_result), 'h80);
    chk("R2 alloc bit cleared", int'(int_status[3]), 0);
    do_cmd(3); tick();
    do_cmd(4); tick();
    tick();
    chk("R3 retry after free", int'(alloc_result), 1);
    chk("R2 alloc bit set", int'(int_status[3]), 1);

    // transmit, completion pushed while acknowledge pops (R8 R9)
    pnum_we = 1; pnum_page = 2; tick();
    do_cmd(6); tick();
    tick();
    tick();
    tx_done = 1; ack_we = 1; ack_byte = 8'h02; tick();
    chk("R9 completion queued", int'(doneq_head), 2);
    ack_we = 1; ack_byte = 8'h02; tick();
    chk("R9 ack pops completion", int'(doneq_head), 'h80);

    // overflow the transmit queue (R13)
    for (int i = 0; i < 6; i++) begin do_cmd(6); tick(); end
    for (int i = 0; i < 9; i++) begin if (i % 3 == 2) tx_done = 1; tick(); end
    do_cmd(7); tick();

    // auto release (R9)
    auto_release = 1;
    tx_done = 1; tick();
    pnum_we = 1; pnum_page = 3; tick();
    do_cmd(6); tick();
    tick(); tick();
    tx_done = 1; tick();
    auto_release = 0;

    // manager reset with a same-cycle receive request (R12)
    rx_alloc_req = 1; do_cmd(2); tick();
    chk("R12 pool emptied", int'(pages_used), 0);
    chk("R12 result zero", int'(alloc_result), 0);

    // receive pops and the receive bit (R6 R13)
    rx_alloc_req = 1; tick();
    rx_alloc_req = 1; tick();
    do_cmd(3); tick();
    chk("R6 rcv bit kept", int'(int_status[0]), 1);
    do_cmd(3); tick();
    chk("R6 rcv bit cleared", int'(int_status[0]), 0);
    do_cmd(3); tick();
    chk("R13 empty pop ignored", int'(rxq_head), 'h80);
    chk("R13 empty pop frees nothing", int'(pages_used), 2);

    // free by packet number (R7)
    pnum_we = 1; pnum_page = 1; tick();
    do_cmd(5); tick();
    chk("R7 page freed", int'(pages_used), 1);

    // acknowledge leaves bits 0 and 3 (R11)
    rx_alloc_req = 1; tick();
    ack_we = 1; ack_byte = 8'hFF; tick();
    chk("R11 rcv survives ack", int'(int_status[0]), 1);
    chk("R11 clearable bits gone", int'(int_status & 8'hD2), 0);
    mask_we = 1; mask_byte = 8'h00; tick();
    chk("R10 masked irq low", int'(irq), 0);

    // random overlap phase
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[2:0] < 3) begin
        cmd_we = 1;
        cmd_byte = {lfsr[7:5], 5'b0};
        if (lfsr[7:5] == 3'd2 && lfsr[11]) cmd_byte = 8'hC0;
      end
      rx_alloc_req = lfsr[8] & lfsr[3];
      tx_done      = lfsr[9];
      if (lfsr[4] & lfsr[10]) begin ack_we = 1; ack_byte = {lfsr[15:9], lfsr[1]}; end
      if (lfsr[14:12] == 3'd0) begin pnum_we = 1; pnum_page = lfsr[1:0]; end
      if (lfsr[15:13] == 3'd7) begin mask_we = 1; mask_byte = lfsr[7:0]; end
      if (lfsr[11:6] == 6'd0) auto_release = ~auto_release;
      tick();
    end

    summary();
  end

endmodule